// File: doc/BRIEF.md
# Low-power mode controller

This block moves a small processor between a running state and three power-saving states. The CPU starts a transition with a one-cycle sleep command, and a two-bit mode code picks the target state. In light sleep only the CPU clock stops, and the peripherals keep running at a divided rate. In deep standby the main oscillator stops, so every clock stops and the I/O pads float. In sub-sleep the oscillator also stops and the pads keep their last values. The block drives the CPU clock enable, a peripheral clock-enable tick, the oscillator run enable and a two-bit pad-control code.

An interrupt request can wake the block only when the global mask is clear and the enable bit for that source is set. Light sleep wakes in the cycle after the request. The two states that stop the oscillator first restart it and then wait a settling time set by a 3-bit field before they signal the interrupt. The external reset pin (active low) overrides every state. When the pin returns high the block raises a one-cycle reset-exception strobe. It delays that strobe until the oscillator has settled if the pin fell while the oscillator was stopped.

Top module: `lpm_ctrl`

## Requirements
- R1: While the block reset `rst_n` is low and in the first cycle after it is released, the block is in the running state: CPU clock enable 1, peripheral tick 1, oscillator enable 1, pad code 00 and both strobes 0.
- R2: In the running state, a sleep command with mode code 00 enters light sleep, 01 enters deep standby and 10 enters sub-sleep, each on the next clock edge. Mode code 11 is ignored, and the block stays running.
- R3: A sleep command that arrives in any state other than the running state has no effect.
- R4: In light sleep the CPU clock enable is 0, the oscillator enable is 1 and the pad code is 00. The peripheral tick is 1 in the first sleep cycle and then once every 2^d cycles, where d is the 3-bit divide field.
- R5: In deep standby the oscillator enable, CPU clock enable and peripheral tick are all 0, and the pad code is 01 (high impedance).
- R6: In sub-sleep the oscillator enable, CPU clock enable and peripheral tick are all 0, and the pad code is 10 (hold last value).
- R7: A request wakes the block only if the global mask is 0 and at least one bit of (request AND enable) is 1. Otherwise the block stays in its power-saving state.
- R8: A qualified request in light sleep produces the wake-interrupt strobe in the next cycle, with no settling wait.
- R9: A qualified request in deep standby or sub-sleep sets the oscillator enable in the next cycle. The CPU clock stays off and the pad code keeps the value of the state that was left for exactly BASE*2^s cycles, where s is the settling field. The wake strobe follows, and requests made during the wait have no effect.
- R10: Each strobe is one cycle wide. The two strobes are never high together. In the cycle after a strobe the block is running with all clocks enabled and pad code 00.
- R11: In the cycle after the reset pin is seen low, the block is in reset hold: CPU clock 0, peripheral tick 0, oscillator 1, pad code 00. If the pin fell in the running state or in light sleep, the reset-exception strobe comes in the cycle after the pin is seen high.
- R12: If the reset pin fell in deep standby, sub-sleep or the settling wait, the reset-exception strobe comes no earlier than BASE*2^s cycles after reset hold is entered. It comes in the cycle after the pin is seen high once that time has passed.
- R13: A low reset pin takes priority over a sleep command and over a qualified wake request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Block reset, asynchronous assert, active low |
| pin_rst_n | input | 1 | External reset pin, synchronous sample, active low |
| sleep_cmd_i | input | 1 | One-cycle sleep command from the CPU |
| mode_sel_i | input | 2 | Target state: 00 light sleep, 01 deep standby, 10 sub-sleep |
| settle_sel_i | input | 3 | Settling field s, wait = BASE*2^s cycles |
| pdiv_sel_i | input | 3 | Peripheral divide field d, ratio 2^d |
| irq_req_i | input | IRQ_W | Interrupt requests |
| irq_en_i | input | IRQ_W | Enable bit for each source |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks wake-up |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock-enable tick |
| osc_en_o | output | 1 | Main oscillator run enable |
| io_mode_o | output | 2 | Pad control: 00 normal, 01 high impedance, 10 hold |
| wake_irq_o | output | 1 | One-cycle wake-interrupt strobe |
| rst_exc_o | output | 1 | One-cycle reset-exception strobe |

## Verification
The bench sweeps all eight divide codes in light sleep and all eight settling codes from both oscillator-off states. An off-by-one in the divider or the settling timer therefore shows up as a tick or a strobe one cycle early or late. It checks wake-up against a mask that is set and against an enable on the wrong source: a weak qualifier would wake on one of these. It also checks a sleep command given while already asleep, which a design that decodes commands in every state would take as a jump between states. A reset pin that is released early from standby must not give an early exception. A reset pin in the same cycle as a command or a wake request must win, or the block would enter sleep or raise a wake strobe inside reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_LSLEEP, ST_DSTBY, ST_SUBSLP,
    ST_SETTLE, ST_WAKE, ST_RHOLD, ST_REXC
  } lpm_state_e;

  typedef enum logic [1:0] {
    PAD_NORMAL = 2'b00,
    PAD_HIZ    = 2'b01,
    PAD_HOLD   = 2'b10
  } pad_mode_e;

  localparam logic [1:0] MODE_LSLEEP = 2'b00;
  localparam logic [1:0] MODE_DSTBY  = 2'b01;
  localparam logic [1:0] MODE_SUBSLP = 2'b10;
endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] req_i,
  input  logic [IRQ_W-1:0] en_i,
  input  logic             mask_i,
  output logic             wake_o
);
  always_comb begin
    wake_o = !mask_i && (|(req_i & en_i));
  end
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int SEL_W = 3,
  parameter int BASE  = 8192,
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = arm_i ? (CNT_W'(BASE) << sel_i) : '0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/lpm_pclk_div.sv
module lpm_pclk_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DCNT_W = (2 ** SEL_W) - 1;

  logic [DCNT_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask  = (DCNT_W'(1) << sel_i) - DCNT_W'(1);
    cnt_d = run_i ? cnt_q + DCNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && ((cnt_q & mask) == '0);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int IRQ_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SETTLE_BASE = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_rst_n,
  input  logic             sleep_cmd_i,
  input  logic [1:0]       mode_sel_i,
  input  logic [SEL_W-1:0] settle_sel_i,
  input  logic [SEL_W-1:0] pdiv_sel_i,
  input  logic [IRQ_W-1:0] irq_req_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             irq_mask_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             osc_en_o,
  output logic [1:0]       io_mode_o,
  output logic             wake_irq_o,
  output logic             rst_exc_o
);
  import lpm_pkg::*;

  localparam int MAX_SHIFT = (2 ** SEL_W) - 1;
  localparam int CNT_W     = $clog2(SETTLE_BASE) + MAX_SHIFT + 1;

  lpm_state_e state_q, state_d;
  logic       sub_q, sub_d;
  logic       wake_ok, tmr_load, tmr_arm, tmr_done, div_tick;

  lpm_wake_qual #(.IRQ_W(IRQ_W)) wq_i (
    .req_i (irq_req_i),
    .en_i  (irq_en_i),
    .mask_i(irq_mask_i),
    .wake_o(wake_ok)
  );

  lpm_settle_timer #(.SEL_W(SEL_W), .BASE(SETTLE_BASE), .CNT_W(CNT_W)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .arm_i (tmr_arm),
    .sel_i (settle_sel_i),
    .done_o(tmr_done)
  );

  lpm_pclk_div #(.SEL_W(SEL_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == ST_LSLEEP),
    .sel_i (pdiv_sel_i),
    .tick_o(div_tick)
  );

  // next-state logic; the reset pin outranks everything else
  always_comb begin
    state_d  = state_q;
    sub_d    = sub_q;
    tmr_load = 1'b0;
    tmr_arm  = 1'b0;
    if (!pin_rst_n) begin
      if (state_q != ST_RHOLD) begin
        state_d  = ST_RHOLD;
        tmr_load = 1'b1;
        tmr_arm  = (state_q == ST_DSTBY) || (state_q == ST_SUBSLP) ||
                   (state_q == ST_SETTLE);
      end
    end else begin
      case (state_q)
        ST_RUN: begin
          if (sleep_cmd_i) begin
            case (mode_sel_i)
              MODE_LSLEEP: state_d = ST_LSLEEP;
              MODE_DSTBY:  begin state_d = ST_DSTBY;  sub_d = 1'b0; end
              MODE_SUBSLP: begin state_d = ST_SUBSLP; sub_d = 1'b1; end
              default:     state_d = ST_RUN;
            endcase
          end
        end
        ST_LSLEEP: if (wake_ok) state_d = ST_WAKE;
        ST_DSTBY, ST_SUBSLP: begin
          if (wake_ok) begin
            state_d  = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_arm  = 1'b1;
          end
        end
        ST_SETTLE: if (tmr_done) state_d = ST_WAKE;
        ST_RHOLD:  if (tmr_done) state_d = ST_REXC;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      sub_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
    end
  end

  // output decode from the registered state
  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    osc_en_o     = 1'b1;
    io_mode_o    = PAD_NORMAL;
    case (state_q)
      ST_RUN, ST_WAKE, ST_REXC: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
      end
      ST_LSLEEP: per_clk_en_o = div_tick;
      ST_DSTBY: begin
        osc_en_o  = 1'b0;
        io_mode_o = PAD_HIZ;
      end
      ST_SUBSLP: begin
        osc_en_o  = 1'b0;
        io_mode_o = PAD_HOLD;
      end
      ST_SETTLE: io_mode_o = sub_q ? PAD_HOLD : PAD_HIZ;
      default: ;
    endcase
  end

  assign wake_irq_o = (state_q == ST_WAKE);
  assign rst_exc_o  = (state_q == ST_REXC);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_rst_n,
  input logic [IRQ_W-1:0] irq_req_i,
  input logic [IRQ_W-1:0] irq_en_i,
  input logic             irq_mask_i,
  input logic             cpu_clk_en_o,
  input logic             per_clk_en_o,
  input logic             osc_en_o,
  input logic [1:0]       io_mode_o,
  input logic             wake_irq_o,
  input logic             rst_exc_o
);
  logic qualified;
  assign qualified = !irq_mask_i && (|(irq_req_i & irq_en_i));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_irq_o, rst_exc_o}));

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_irq_o || rst_exc_o) && pin_rst_n) |=>
      (!wake_irq_o && !rst_exc_o && cpu_clk_en_o && per_clk_en_o && io_mode_o == 2'b00));

  assert_hiz_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_mode_o == 2'b01) |-> (!cpu_clk_en_o && !per_clk_en_o));

  assert_hold_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_mode_o == 2'b10) |-> (!cpu_clk_en_o && !per_clk_en_o));

  assert_no_spurious_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en_o && pin_rst_n && !qualified) |=> !osc_en_o);

  assert_wake_after_osc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq_o) |-> $past(osc_en_o));

  assert_pin_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_rst_n |=> (!cpu_clk_en_o && !per_clk_en_o && osc_en_o &&
                    io_mode_o == 2'b00 && !wake_irq_o && !rst_exc_o));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.IRQ_W(IRQ_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_rst_n   (pin_rst_n),
  .irq_req_i   (irq_req_i),
  .irq_en_i    (irq_en_i),
  .irq_mask_i  (irq_mask_i),
  .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o),
  .osc_en_o    (osc_en_o),
  .io_mode_o   (io_mode_o),
  .wake_irq_o  (wake_irq_o),
  .rst_exc_o   (rst_exc_o)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  localparam int IRQ_W = 4;
  localparam int SEL_W = 3;
  localparam int BASE  = 4;

  // expected bundles {cpu, per, osc, io[1:0], wake, rexc}
  localparam logic [6:0] B_RUN   = 7'b1110000;
  localparam logic [6:0] B_SLON  = 7'b0110000;
  localparam logic [6:0] B_SLOFF = 7'b0010000;
  localparam logic [6:0] B_RHOLD = 7'b0010000;
  localparam logic [6:0] B_STBY  = 7'b0000100;
  localparam logic [6:0] B_SUB   = 7'b0001000;
  localparam logic [6:0] B_SETHZ = 7'b0010100;
  localparam logic [6:0] B_SETHD = 7'b0011000;
  localparam logic [6:0] B_WAKE  = 7'b1110010;
  localparam logic [6:0] B_REXC  = 7'b1110001;

  logic clk = 1'b0;
  logic rst_n, pin_rst_n, sleep_cmd, irq_mask;
  logic [1:0] mode_sel;
  logic [SEL_W-1:0] settle_sel, pdiv_sel;
  logic [IRQ_W-1:0] irq_req, irq_en;
  logic cpu_en, per_en, osc_en, wake, rexc;
  logic [1:0] io_mode;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lpm_ctrl #(.IRQ_W(IRQ_W), .SEL_W(SEL_W), .SETTLE_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .sleep_cmd_i(sleep_cmd),
    .mode_sel_i(mode_sel), .settle_sel_i(settle_sel), .pdiv_sel_i(pdiv_sel),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .irq_mask_i(irq_mask),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
    .io_mode_o(io_mode), .wake_irq_o(wake), .rst_exc_o(rexc)
  );

  function automatic logic [6:0] outs();
    return {cpu_en, per_en, osc_en, io_mode, wake, rexc};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic command(logic [1:0] m);
    sleep_cmd = 1'b1;
    mode_sel  = m;
    step();
    sleep_cmd = 1'b0;
  endtask

  task automatic wake_pulse();
    irq_req = 4'b0001;
    irq_en  = 4'b0001;
    step();
    irq_req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_rst_n = 1'b1; sleep_cmd = 1'b0; mode_sel = '0;
    settle_sel = '0; pdiv_sel = '0; irq_req = '0; irq_en = '0; irq_mask = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 32'(outs()), 32'(B_RUN));
    rst_n = 1'b1;
    step();
    check("R1 after reset", 32'(outs()), 32'(B_RUN));

    // R2: code 11 ignored
    command(2'b11);
    check("R2 mode 11 ignored", 32'(outs()), 32'(B_RUN));

    // R4: divide sweep in light sleep, R8 wake, R10 return
    for (int d = 0; d < 8; d++) begin
      int bad;
      bad = 0;
      pdiv_sel = SEL_W'(d);
      command(2'b00);
      check("R2 enter light sleep", 32'(outs()), 32'(B_SLON));
      for (int k = 0; k < 2 * (1 << d); k++) begin
        if (outs() !== (((k % (1 << d)) == 0) ? B_SLON : B_SLOFF)) bad++;
        step();
      end
      check("R4 divided peripheral ticks", 32'(bad), 32'd0);
      wake_pulse();
      check("R8 sleep wake strobe", 32'(outs()), 32'(B_WAKE));
      step();
      check("R10 back to run after wake", 32'(outs()), 32'(B_RUN));
    end

    // R3, R7 in light sleep
    pdiv_sel = '0;
    command(2'b00);
    command(2'b01);
    check("R3 command ignored in sleep", 32'(outs()), 32'(B_SLON));
    irq_req = 4'b0010; irq_en = 4'b0001;
    step();
    check("R7 enable on other source", 32'(outs()), 32'(B_SLON));
    irq_en = 4'b0010; irq_mask = 1'b1;
    step();
    check("R7 global mask blocks", 32'(outs()), 32'(B_SLON));
    irq_mask = 1'b0;
    step();
    check("R7 qualified request wakes", 32'(outs()), 32'(B_WAKE));
    irq_req = '0;
    step();
    check("R10 run after wake", 32'(outs()), 32'(B_RUN));

    // R5, R6, R9 settling sweep from both oscillator-off states
    for (int m = 1; m < 3; m++) begin
      for (int s = 0; s < 8; s++) begin
        int bad;
        int nwait;
        bad = 0;
        nwait = BASE << s;
        settle_sel = SEL_W'(s);
        command(2'(m));
        check(m == 1 ? "R5 standby outputs" : "R6 subsleep outputs", 32'(outs()),
              32'(m == 1 ? B_STBY : B_SUB));
        irq_req = 4'b0100; irq_en = 4'b0011;
        step();
        check("R7 unqualified stays off", 32'(outs()), 32'(m == 1 ? B_STBY : B_SUB));
        irq_req = '0;
        command(2'b00);
        check("R3 command ignored when off", 32'(outs()), 32'(m == 1 ? B_STBY : B_SUB));
        wake_pulse();
        check("R9 oscillator restarts", 32'(outs()), 32'(m == 1 ? B_SETHZ : B_SETHD));
        for (int c = 1; c < nwait; c++) begin
          irq_req = (c == 1) ? 4'b0001 : 4'b0000;
          step();
          if (outs() !== (m == 1 ? B_SETHZ : B_SETHD)) bad++;
        end
        irq_req = '0;
        check("R9 settling window held", 32'(bad), 32'd0);
        step();
        check("R9 wake after settling", 32'(outs()), 32'(B_WAKE));
        step();
        check("R10 run after settle wake", 32'(outs()), 32'(B_RUN));
      end
    end

    // R11 from run
    pin_rst_n = 1'b0;
    step();
    check("R11 hold from run", 32'(outs()), 32'(B_RHOLD));
    step();
    step();
    check("R11 hold persists", 32'(outs()), 32'(B_RHOLD));
    pin_rst_n = 1'b1;
    step();
    check("R11 exception after release", 32'(outs()), 32'(B_REXC));
    step();
    check("R10 run after exception", 32'(outs()), 32'(B_RUN));

    // R11 from light sleep
    command(2'b00);
    pin_rst_n = 1'b0;
    step();
    check("R11 hold from sleep", 32'(outs()), 32'(B_RHOLD));
    pin_rst_n = 1'b1;
    step();
    check("R11 exception from sleep", 32'(outs()), 32'(B_REXC));
    step();

    // R12 early release from standby and subsleep
    for (int m = 1; m < 3; m++) begin
      for (int s = 0; s < 3; s++) begin
        int bad;
        int nwait;
        bad = 0;
        nwait = BASE << s;
        settle_sel = SEL_W'(s);
        command(2'(m));
        pin_rst_n = 1'b0;
        step();
        pin_rst_n = 1'b1;
        check("R12 hold entered", 32'(outs()), 32'(B_RHOLD));
        for (int c = 1; c < nwait; c++) begin
          step();
          if (outs() !== B_RHOLD) bad++;
        end
        check("R12 no early exception", 32'(bad), 32'd0);
        step();
        check("R12 exception after settle", 32'(outs()), 32'(B_REXC));
        step();
      end
    end

    // R12 long hold from standby
    settle_sel = 3'd1;
    command(2'b01);
    pin_rst_n = 1'b0;
    repeat (BASE * 2 + 5) step();
    check("R12 long hold", 32'(outs()), 32'(B_RHOLD));
    pin_rst_n = 1'b1;
    step();
    check("R12 exception on release", 32'(outs()), 32'(B_REXC));
    step();

    // R13 priority
    sleep_cmd = 1'b1; mode_sel = 2'b00; pin_rst_n = 1'b0;
    step();
    sleep_cmd = 1'b0;
    check("R13 pin beats command", 32'(outs()), 32'(B_RHOLD));
    pin_rst_n = 1'b1;
    step();
    check("R13 exception after command clash", 32'(outs()), 32'(B_REXC));
    step();
    command(2'b00);
    irq_req = 4'b0001; irq_en = 4'b0001; pin_rst_n = 1'b0;
    step();
    irq_req = '0;
    check("R13 pin beats wake", 32'(outs()), 32'(B_RHOLD));
    pin_rst_n = 1'b1;
    step();
    check("R13 exception after wake clash", 32'(outs()), 32'(B_REXC));
    step();
    check("R10 final run", 32'(outs()), 32'(B_RUN));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule